// File: doc/BRIEF.md
# Video Sync Delay and Routing Unit

This unit sits between a graphics controller and the video output stage. It takes one shared sync input, which carries either horizontal sync or composite sync, plus a vertical sync input. It produces three things: a horizontal sync output, a vertical sync output, and a composite-sync level that the green DAC channel uses to inject sync. When the shared input is sampled, it goes through a register chain that matches the latency of the pixel data path. A 4-bit position field then adds between 0 and 15 more pixel clocks for fine horizontal placement.

All controls are static register bits presented as inputs. A path decoder turns the sync-on-green bit and the delay-bypass bit into one of three path modes:

- `PATH_DIRECT`: the horizontal output is a combinational pass-through.
- `PATH_MATCHED`: the horizontal output comes from the delay chain.
- `PATH_COMPOSITE`: the delay chain feeds green injection and the horizontal output passes through.

The mode is chosen in each cycle from the current control bits. There are no registered transitions: every mode is reachable from every other mode as soon as the controls change.

Each of the two sync outputs has its own output stage. The stage applies a polarity bit and then a 2-bit drive code: normal, forced low, forced high or high impedance. A power-down bit freezes the delay chain, and the chain keeps its contents until the bit is cleared.

Top module: `sync_route_unit`

## Requirements
- R1: When `sog_en_i` is 0, `green_sync_o` is 0 whatever the shared input does.
- R2: When `sog_en_i` is 1, `green_sync_o` follows the shared input after exactly PIPE_LAT+`pos_i` rising clock edges, counting the edge that first samples it. The result is XOR-ed with `cs_inv_i`.
- R3: When `sog_en_i` is 0 and `dly_bypass_i` is 1, `hs_o` equals `sync_hc_i` XOR `hs_inv_i` combinationally, with no clock edge between them.
- R4: When `sog_en_i` is 0 and `dly_bypass_i` is 0, `hs_o` follows `sync_hc_i` after exactly PIPE_LAT+`pos_i` rising edges, for every `pos_i` from 0 to 15.
- R5: When `sog_en_i` is 1, `dly_bypass_i` has no effect and `hs_o` is a combinational copy of `sync_hc_i` XOR `hs_inv_i`.
- R6: `vs_o` equals `sync_v_i` XOR `vs_inv_i` combinationally when its drive code is normal.
- R7: `hs_inv_i` inverts the horizontal output in both the combinational modes and the delayed mode.
- R8: The drive codes on `hs_mode_i` and `vs_mode_i` are:
  - 00: normal, output enable 1.
  - 01: forced low, output 0 and enable 1.
  - 10: forced high, output 1 and enable 1.
  - 11: high impedance, output enable 0 and output level 0.
- R9: While `dly_pwrdn_i` is 1, the delay chain does not advance. A pulse already inside it emerges only after the remaining enabled edges.
- R10: Reset clears the delay chain, so the delayed outputs read 0 during reset and until new input data has had time to pass through the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_hc_i | input | 1 | Shared horizontal/composite sync input |
| sync_v_i | input | 1 | Vertical sync input |
| sog_en_i | input | 1 | Use shared input as composite sync for green injection |
| dly_bypass_i | input | 1 | 1: horizontal sync bypasses the delay chain |
| pos_i | input | 4 | Extra delay in pixel clocks (0..15) |
| cs_inv_i | input | 1 | Invert composite sync before green injection |
| hs_inv_i | input | 1 | Invert horizontal output |
| vs_inv_i | input | 1 | Invert vertical output |
| hs_mode_i | input | 2 | Horizontal drive code |
| vs_mode_i | input | 2 | Vertical drive code |
| dly_pwrdn_i | input | 1 | Freeze the delay chain |
| hs_o | output | 1 | Horizontal sync output level |
| hs_oe_o | output | 1 | Horizontal output enable |
| vs_o | output | 1 | Vertical sync output level |
| vs_oe_o | output | 1 | Vertical output enable |
| green_sync_o | output | 1 | Composite sync level for green injection |

## Verification
Power-down and delay counting can fall in the same cycle: a sync pulse can be halfway down the chain in the cycle the power-down bit rises. To provoke this, the bench launches a single-cycle pulse and raises the freeze bit two edges later. It holds the bit for five edges and then releases it. The case is judged by exact edge counting: the output must stay low through the frozen edges and rise only after the two enabled edges still owed. A second overlap is a forced drive code applied while a delayed pulse is emerging; there the drive code must win in the same cycle.

// File: rtl/sync_route_pkg.sv
package sync_route_pkg;

    typedef enum logic [1:0] {
        DRV_NORMAL = 2'b00,
        DRV_LOW    = 2'b01,
        DRV_HIGH   = 2'b10,
        DRV_HIZ    = 2'b11
    } drive_mode_e;

    typedef enum logic [1:0] {
        PATH_DIRECT    = 2'b00,
        PATH_MATCHED   = 2'b01,
        PATH_COMPOSITE = 2'b10
    } path_mode_e;

endpackage

// File: rtl/sync_delay_line.sv
module sync_delay_line #(
    parameter int PIPE_LAT = 4,
    parameter int POS_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    input  logic             din,
    input  logic [POS_W-1:0] pos,
    output logic             dout
);
    localparam int POS_MAX = (1 << POS_W) - 1;
    localparam int DEPTH   = PIPE_LAT + POS_MAX;
    localparam int IDX_W   = $clog2(DEPTH);

    logic [DEPTH-1:0] taps;
    logic [IDX_W-1:0] tap_sel;

    // stage 0 is the input latch; each later stage is one more pixel clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (adv_en) begin
            taps <= {taps[DEPTH-2:0], din};
        end
    end

    assign tap_sel = IDX_W'(PIPE_LAT - 1) + IDX_W'(pos);
    assign dout    = taps[tap_sel];

endmodule

// File: rtl/sync_path_sel.sv
module sync_path_sel
    import sync_route_pkg::*;
(
    input  logic       raw_in,
    input  logic       delayed_in,
    input  logic       sog_en,
    input  logic       dly_bypass,
    input  logic       cs_inv,
    output path_mode_e mode,
    output logic       h_pre,
    output logic       green
);
    always_comb begin
        if (sog_en) begin
            mode = PATH_COMPOSITE;
        end else if (dly_bypass) begin
            mode = PATH_DIRECT;
        end else begin
            mode = PATH_MATCHED;
        end
    end

    always_comb begin
        h_pre = 1'b0;
        green = 1'b0;
        unique case (mode)
            PATH_DIRECT: begin
                h_pre = raw_in;
                green = 1'b0;
            end
            PATH_MATCHED: begin
                h_pre = delayed_in;
                green = 1'b0;
            end
            PATH_COMPOSITE: begin
                h_pre = raw_in;
                green = delayed_in ^ cs_inv;
            end
            default: begin
                h_pre = 1'b0;
                green = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sync_out_stage.sv
module sync_out_stage
    import sync_route_pkg::*;
(
    input  logic        din,
    input  logic        inv,
    input  drive_mode_e drv,
    output logic        dout,
    output logic        oe
);
    logic level;

    assign level = din ^ inv;

    always_comb begin
        dout = 1'b0;
        oe   = 1'b0;
        unique case (drv)
            DRV_NORMAL: begin
                dout = level;
                oe   = 1'b1;
            end
            DRV_LOW: begin
                dout = 1'b0;
                oe   = 1'b1;
            end
            DRV_HIGH: begin
                dout = 1'b1;
                oe   = 1'b1;
            end
            DRV_HIZ: begin
                dout = 1'b0;
                oe   = 1'b0;
            end
            default: begin
                dout = 1'b0;
                oe   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sync_route_unit.sv
module sync_route_unit
    import sync_route_pkg::*;
#(
    parameter int PIPE_LAT = 4,
    parameter int POS_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_hc_i,
    input  logic             sync_v_i,
    input  logic             sog_en_i,
    input  logic             dly_bypass_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             cs_inv_i,
    input  logic             hs_inv_i,
    input  logic             vs_inv_i,
    input  logic [1:0]       hs_mode_i,
    input  logic [1:0]       vs_mode_i,
    input  logic             dly_pwrdn_i,
    output logic             hs_o,
    output logic             hs_oe_o,
    output logic             vs_o,
    output logic             vs_oe_o,
    output logic             green_sync_o
);
    localparam int N_OUT = 2;

    logic       delayed;
    logic       h_pre;
    path_mode_e path_mode;

    logic [N_OUT-1:0] stage_din;
    logic [N_OUT-1:0] stage_inv;
    logic [N_OUT-1:0] stage_dout;
    logic [N_OUT-1:0] stage_oe;
    logic [1:0]       stage_drv [N_OUT];

    sync_delay_line #(
        .PIPE_LAT (PIPE_LAT),
        .POS_W    (POS_W)
    ) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_en (!dly_pwrdn_i),
        .din    (sync_hc_i),
        .pos    (pos_i),
        .dout   (delayed)
    );

    sync_path_sel u_path (
        .raw_in     (sync_hc_i),
        .delayed_in (delayed),
        .sog_en     (sog_en_i),
        .dly_bypass (dly_bypass_i),
        .cs_inv     (cs_inv_i),
        .mode       (path_mode),
        .h_pre      (h_pre),
        .green      (green_sync_o)
    );

    // index 0: horizontal, index 1: vertical
    assign stage_din    = {sync_v_i, h_pre};
    assign stage_inv    = {vs_inv_i, hs_inv_i};
    assign stage_drv[0] = hs_mode_i;
    assign stage_drv[1] = vs_mode_i;

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        sync_out_stage u_stage (
            .din  (stage_din[g]),
            .inv  (stage_inv[g]),
            .drv  (drive_mode_e'(stage_drv[g])),
            .dout (stage_dout[g]),
            .oe   (stage_oe[g])
        );
    end

    assign hs_o    = stage_dout[0];
    assign hs_oe_o = stage_oe[0];
    assign vs_o    = stage_dout[1];
    assign vs_oe_o = stage_oe[1];

endmodule

// File: rtl/sync_route_chk.sv
module sync_route_chk #(
    parameter int POS_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_hc_i,
    input logic             sync_v_i,
    input logic             sog_en_i,
    input logic             dly_bypass_i,
    input logic [POS_W-1:0] pos_i,
    input logic             hs_inv_i,
    input logic             vs_inv_i,
    input logic [1:0]       hs_mode_i,
    input logic [1:0]       vs_mode_i,
    input logic             dly_pwrdn_i,
    input logic             hs_o,
    input logic             hs_oe_o,
    input logic             vs_o,
    input logic             vs_oe_o,
    input logic             green_sync_o
);
    // R1
    green_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sog_en_i |-> !green_sync_o);

    // R3
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sog_en_i && dly_bypass_i && hs_mode_i == 2'b00) |-> (hs_o == (sync_hc_i ^ hs_inv_i)));

    // R5
    sog_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sog_en_i && hs_mode_i == 2'b00) |-> (hs_o == (sync_hc_i ^ hs_inv_i)));

    // R6
    vs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_mode_i == 2'b00) |-> (vs_o == (sync_v_i ^ vs_inv_i)));

    // R8
    hiz_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_mode_i == 2'b11) |-> (!hs_oe_o && !hs_o));

    // R8
    vs_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_mode_i == 2'b01) |-> (vs_oe_o && !vs_o));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dly_pwrdn_i) && !sog_en_i && !dly_bypass_i
         && $past(!sog_en_i && !dly_bypass_i) && $stable(pos_i) && $stable(hs_inv_i)
         && hs_mode_i == 2'b00 && $past(hs_mode_i) == 2'b00) |-> $stable(hs_o));

endmodule

bind sync_route_unit sync_route_chk #(.POS_W(POS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_hc_i    (sync_hc_i),
    .sync_v_i     (sync_v_i),
    .sog_en_i     (sog_en_i),
    .dly_bypass_i (dly_bypass_i),
    .pos_i        (pos_i),
    .hs_inv_i     (hs_inv_i),
    .vs_inv_i     (vs_inv_i),
    .hs_mode_i    (hs_mode_i),
    .vs_mode_i    (vs_mode_i),
    .dly_pwrdn_i  (dly_pwrdn_i),
    .hs_o         (hs_o),
    .hs_oe_o      (hs_oe_o),
    .vs_o         (vs_o),
    .vs_oe_o      (vs_oe_o),
    .green_sync_o (green_sync_o)
);

// File: tb/sync_route_unit_test.sv
module sync_route_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int FLUSH      = LAT + 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_hc_i, sync_v_i, sog_en_i, dly_bypass_i;
    logic [3:0] pos_i;
    logic       cs_inv_i, hs_inv_i, vs_inv_i, dly_pwrdn_i;
    logic [1:0] hs_mode_i, vs_mode_i;
    logic       hs_o, hs_oe_o, vs_o, vs_oe_o, green_sync_o;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_route_unit #(.PIPE_LAT(LAT), .POS_W(4)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_hc_i    (sync_hc_i),
        .sync_v_i     (sync_v_i),
        .sog_en_i     (sog_en_i),
        .dly_bypass_i (dly_bypass_i),
        .pos_i        (pos_i),
        .cs_inv_i     (cs_inv_i),
        .hs_inv_i     (hs_inv_i),
        .vs_inv_i     (vs_inv_i),
        .hs_mode_i    (hs_mode_i),
        .vs_mode_i    (vs_mode_i),
        .dly_pwrdn_i  (dly_pwrdn_i),
        .hs_o         (hs_o),
        .hs_oe_o      (hs_oe_o),
        .vs_o         (vs_o),
        .vs_oe_o      (vs_oe_o),
        .green_sync_o (green_sync_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // launch a one-cycle pulse, return edge count until the chosen output rises
    task automatic measure(input bit use_green, output int edges);
        edges = -1;
        @(negedge clk);
        sync_hc_i = 1'b1;
        for (int j = 1; j <= 40; j++) begin
            @(posedge clk);
            @(negedge clk);
            if (j == 1) sync_hc_i = 1'b0;
            if ((use_green ? green_sync_o : hs_o) && edges < 0) edges = j;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; sync_hc_i = 1'b1; sync_v_i = 1'b0;
        sog_en_i = 1'b0; dly_bypass_i = 1'b0; pos_i = 4'd0;
        cs_inv_i = 1'b0; hs_inv_i = 1'b0; vs_inv_i = 1'b0;
        hs_mode_i = 2'b00; vs_mode_i = 2'b00; dly_pwrdn_i = 1'b0;
        idle(3);
        check("R10 hs_o in reset", int'(hs_o), 0);
        check("R1 green in reset", int'(green_sync_o), 0);
        check("R8 hs_oe in reset", int'(hs_oe_o), 1);
        sync_hc_i = 1'b0;
        rst_n = 1'b1;
        idle(FLUSH);
    endtask

    task automatic t_vsync;
        for (int k = 0; k < 4; k++) begin
            sync_v_i = k[0]; vs_inv_i = k[1];
            #1;
            check("R6 vs pass-through", int'(vs_o), int'(k[0] ^ k[1]));
        end
        vs_inv_i = 1'b0; sync_v_i = 1'b0;
    endtask

    task automatic t_bypass;
        sog_en_i = 1'b0; dly_bypass_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sync_hc_i = k[0]; hs_inv_i = k[1];
            #1;
            check("R3 R7 bypass hs", int'(hs_o), int'(k[0] ^ k[1]));
            check("R1 green idle", int'(green_sync_o), 0);
        end
        sync_hc_i = 1'b0; hs_inv_i = 1'b0; dly_bypass_i = 1'b0;
        idle(FLUSH);
    endtask

    task automatic t_matched_sweep;
        int e;
        sog_en_i = 1'b0; dly_bypass_i = 1'b0;
        for (int p = 0; p < 16; p++) begin
            pos_i = 4'(p);
            idle(FLUSH);
            measure(1'b0, e);
            check($sformatf("R4 matched delay pos=%0d", p), e, LAT + p);
        end
        // R7 inverted delayed path: idle level high
        hs_inv_i = 1'b1; pos_i = 4'd0;
        idle(2);
        check("R7 inverted idle hs", int'(hs_o), 1);
        hs_inv_i = 1'b0;
    endtask

    task automatic t_composite_sweep;
        int e;
        sog_en_i = 1'b1; cs_inv_i = 1'b0;
        for (int p = 0; p < 16; p++) begin
            pos_i = 4'(p);
            idle(FLUSH);
            measure(1'b1, e);
            check($sformatf("R2 composite delay pos=%0d", p), e, LAT + p);
        end
        cs_inv_i = 1'b1;
        idle(2);
        check("R2 cs invert idle", int'(green_sync_o), 1);
        cs_inv_i = 1'b0;
    endtask

    task automatic t_sog_ignores_bypass;
        sog_en_i = 1'b1;
        for (int b = 0; b < 2; b++) begin
            dly_bypass_i = b[0];
            sync_hc_i = 1'b1;
            #1;
            check("R5 sog hs pass high", int'(hs_o), 1);
            sync_hc_i = 1'b0;
            #1;
            check("R5 sog hs pass low", int'(hs_o), 0);
        end
        dly_bypass_i = 1'b0; sog_en_i = 1'b0;
        idle(FLUSH);
    endtask

    task automatic t_force;
        sync_hc_i = 1'b1; sync_v_i = 1'b1; dly_bypass_i = 1'b1;
        hs_mode_i = 2'b01; vs_mode_i = 2'b01; #1;
        check("R8 hs forced low", int'(hs_o), 0);
        check("R8 vs forced low", int'(vs_o), 0);
        check("R8 hs oe low-force", int'(hs_oe_o), 1);
        sync_hc_i = 1'b0; sync_v_i = 1'b0;
        hs_mode_i = 2'b10; vs_mode_i = 2'b10; #1;
        check("R8 hs forced high", int'(hs_o), 1);
        check("R8 vs forced high", int'(vs_o), 1);
        hs_mode_i = 2'b11; vs_mode_i = 2'b11; #1;
        check("R8 hs hiz oe", int'(hs_oe_o), 0);
        check("R8 vs hiz oe", int'(vs_oe_o), 0);
        hs_mode_i = 2'b00; vs_mode_i = 2'b00; #1;
        check("R8 vs normal oe", int'(vs_oe_o), 1);
        dly_bypass_i = 1'b0;
        idle(FLUSH);
    endtask

    task automatic t_power_down;
        sog_en_i = 1'b0; dly_bypass_i = 1'b0; pos_i = 4'd0;
        idle(FLUSH);
        @(negedge clk);
        sync_hc_i = 1'b1;
        @(negedge clk);          // edge 1 captures
        sync_hc_i = 1'b0;
        @(negedge clk);          // edge 2
        dly_pwrdn_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R9 frozen hs low", int'(hs_o), 0);
        end
        dly_pwrdn_i = 1'b0;
        @(negedge clk);
        check("R9 after one enabled edge", int'(hs_o), 0);
        @(negedge clk);
        check("R9 pulse after owed edges", int'(hs_o), 1);
        @(negedge clk);
        check("R9 pulse one cycle", int'(hs_o), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_vsync();
        t_bypass();
        t_matched_sweep();
        t_composite_sweep();
        t_sog_ignores_bypass();
        t_force();
        t_power_down();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule